// File: doc/BRIEF.md
# Stochastic Rounding Quantizer

This block narrows a signed fixed-point stream to a compact 16-bit storage code without biasing it. Each incoming word carries more fractional precision than the storage grid can hold. The block finds the grid point just below the value and the grid point just above it. It then picks one of the two at random. The chance of landing on the upper point grows with how far the value sits above the lower one. Over many samples the stored codes average back to the original value, which truncation or round-to-nearest cannot guarantee. This matters when small updates would otherwise vanish or drift.

The random draws come from an internal linear-feedback shift register. The register advances once for each word the block accepts, so the sequence of draws is fully reproducible from its seed. Results that do not fit the 16-bit code are clamped to the nearest end of the range and flagged.

Both data sides use a valid/ready handshake, and the block holds a single result register between them. A word is accepted at a rising clock edge when `in_valid` and `in_ready` are both high. A result leaves at a rising clock edge when `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the block holds it unchanged and drops `in_ready`, so back-pressure passes straight to the producer. In every other case `in_ready` is high and a new word may enter in the same cycle that the old result leaves.

Top module: `stoch_round_q`

## Requirements
- R1: The input is a signed 32-bit value with 24 fractional bits, and the output is a signed 16-bit code with 13 fractional bits. The lower candidate is the input arithmetically shifted right by 11 (floor to the grid). The residue is input bits [10:0].
- R2: The result is lower+1 when the 11-bit random word is strictly less than the residue, and the lower candidate otherwise.
- R3: An input whose residue is zero and whose lower candidate fits in 16 bits always produces input bits [26:11] with the saturation flag low.
- R4: If the chosen result exceeds 32767, the output is 0x7FFF with `out_sat`=1. If it is below -32768, the output is 0x8000 with `out_sat`=1. Otherwise `out_sat`=0.
- R5: The random source is a 32-bit Fibonacci LFSR. It shifts left, and the new bit 0 is the XOR of state bits 31, 21, 1 and 0. It loads the nonzero parameter `SEED` at reset. The random word is state bits [10:0] before the shift. The state never becomes zero, and it advances once per accepted input and at no other time.
- R6: An input accepted at a clock edge has its result on the output, with `out_valid` high, straight after that edge. `out_valid` is low after reset.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_sat` stay stable, `out_valid` stays high and `in_ready` is low. Otherwise `in_ready` is high.
- R8: Over many trials of one input value, the mean of the output codes matches that input value to within a small tolerance.
- R9: After reset the LFSR holds `SEED`, so the first accepted input uses the seed's low 11 bits as its random word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | 32 | Signed input, 24 fractional bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Signed result, 13 fractional bits |
| out_sat | output | 1 | Result was clamped |

## Verification
The bench tries several kinds of input. Inputs that sit exactly on the grid show that pass-through is exact and that no random draw leaks in. Inputs with residue just above zero and at the top of the range show whether the strict less-than compare is correct. Values at both ends of the range, with and without a round-up, separate clamping in the saturating direction from plain wrap-around. Long runs of one residue value, at one half and one eighth, check that the rounding has no bias, and random words under random back-pressure confirm exact draw-by-draw agreement with the LFSR sequence.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Feedback mask for a maximal-length 32-bit Fibonacci register:
  // polynomial x^32 + x^22 + x^2 + x + 1 (state bits 31, 21, 1, 0).
  localparam logic [31:0] SQ_TAPS_32 = 32'h8020_0003;

  typedef enum logic {
    SQ_DOWN = 1'b0,
    SQ_UP   = 1'b1
  } sq_dir_e;

endpackage

// File: rtl/sq_lfsr.sv
module sq_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = sq_pkg::SQ_TAPS_32,
  parameter logic [W-1:0] SEED = 32'h1D0F_5A3B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);

  logic [W-1:0] state_q;
  logic         fb;

  // Feedback is the parity of the tapped bits.
  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (adv) begin
      state_q <= {state_q[W-2:0], fb};
    end
  end

  assign state = state_q;

endmodule

// File: rtl/sq_pick.sv
module sq_pick #(
  parameter int IN_W  = 32,
  parameter int RES_W = 11,
  localparam int SW   = IN_W - RES_W + 1
) (
  input  logic [IN_W-1:0]  din,
  input  logic [RES_W-1:0] rnd,
  output sq_pkg::sq_dir_e  dir,
  output logic [SW-1:0]    sum
);

  logic [SW-1:0]    lower;
  logic [RES_W-1:0] residue;

  // Floor to the grid: drop the residue bits and keep the sign, with one
  // spare bit so that lower+1 cannot wrap.
  assign lower   = {din[IN_W-1], din[IN_W-1:RES_W]};
  assign residue = din[RES_W-1:0];

  // Round up with probability residue / 2^RES_W.
  assign dir = (rnd < residue) ? sq_pkg::SQ_UP : sq_pkg::SQ_DOWN;
  assign sum = lower + {{(SW-1){1'b0}}, (dir == sq_pkg::SQ_UP)};

endmodule

// File: rtl/sq_clamp.sv
module sq_clamp #(
  parameter int SW    = 22,
  parameter int OUT_W = 16
) (
  input  logic [SW-1:0]    sum,
  output logic [OUT_W-1:0] code,
  output logic             sat
);

  generate
    if (SW > OUT_W) begin : g_clamp
      localparam logic [SW-1:0] MAXV = {{(SW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
      localparam logic [SW-1:0] MINV = {{(SW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
      logic hi;
      logic lo;

      assign hi = $signed(sum) > $signed(MAXV);
      assign lo = $signed(sum) < $signed(MINV);

      always_comb begin
        if (hi) begin
          code = {1'b0, {(OUT_W-1){1'b1}}};
        end else if (lo) begin
          code = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
          code = sum[OUT_W-1:0];
        end
      end
      assign sat = hi | lo;
    end else begin : g_pass
      assign code = OUT_W'($signed(sum));
      assign sat  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/stoch_round_q.sv
module stoch_round_q #(
  parameter int          IN_W     = 32,
  parameter int          IN_FRAC  = 24,
  parameter int          OUT_W    = 16,
  parameter int          OUT_FRAC = 13,
  parameter int          LFSR_W   = 32,
  parameter logic [31:0] SEED     = 32'h1D0F_5A3B,
  localparam int         RES_W    = IN_FRAC - OUT_FRAC,
  localparam int         SW       = IN_W - RES_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_sat
);

  logic [LFSR_W-1:0] lfsr_q;
  logic              accept;
  sq_pkg::sq_dir_e   dir;
  logic [SW-1:0]     sum;
  logic [OUT_W-1:0]  code;
  logic              sat;

  logic              vld_q;
  logic [OUT_W-1:0]  data_q;
  logic              sat_q;

  // Single result slot: it may be refilled in the same cycle it drains.
  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  sq_lfsr #(
    .W    (LFSR_W),
    .TAPS (sq_pkg::SQ_TAPS_32),
    .SEED (SEED)
  ) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (accept),
    .state (lfsr_q)
  );

  sq_pick #(
    .IN_W  (IN_W),
    .RES_W (RES_W)
  ) u_pick (
    .din (in_data),
    .rnd (lfsr_q[RES_W-1:0]),
    .dir (dir),
    .sum (sum)
  );

  sq_clamp #(
    .SW    (SW),
    .OUT_W (OUT_W)
  ) u_clamp (
    .sum  (sum),
    .code (code),
    .sat  (sat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      sat_q  <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) begin
        data_q <= code;
        sat_q  <= sat;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_sat   = sat_q;

endmodule

// File: rtl/stoch_round_q_chk.sv
module stoch_round_q_chk #(
  parameter int IN_W   = 32,
  parameter int RES_W  = 11,
  parameter int OUT_W  = 16,
  parameter int LFSR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IN_W-1:0]   in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OUT_W-1:0]  out_data,
  input logic              out_sat,
  input logic [LFSR_W-1:0] lfsr_q
);

  localparam int TOP = RES_W + OUT_W - 1;

  logic acc;
  logic on_grid;
  assign acc     = in_valid && in_ready;
  assign on_grid = (in_data[RES_W-1:0] == '0) &&
                   ((&in_data[IN_W-1:TOP]) || !(|in_data[IN_W-1:TOP]));

  p_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sat));

  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_grid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && on_grid |=> out_data == $past(in_data[TOP:RES_W]) && !out_sat);

  p_sat_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sat |->
      (out_data == {1'b0, {(OUT_W-1){1'b1}}}) || (out_data == {1'b1, {(OUT_W-1){1'b0}}}));

  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  p_lfsr_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(lfsr_q));

endmodule

bind stoch_round_q stoch_round_q_chk #(
  .IN_W   (IN_W),
  .RES_W  (RES_W),
  .OUT_W  (OUT_W),
  .LFSR_W (LFSR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sat   (out_sat),
  .lfsr_q    (lfsr_q)
);

// File: tb/test_stoch_round_q.sv
module test_stoch_round_q;

  localparam logic [31:0] SEED = 32'h1D0F_5A3B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        out_sat;

  always #4 clk = ~clk;

  stoch_round_q #(.SEED(SEED)) i_stoch_round_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sat   (out_sat)
  );

  typedef struct {
    logic [15:0] d;
    logic        s;
    int          grp;
    string       req;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] m_lfsr = SEED;
  longint      acc1 = 0;
  longint      acc2 = 0;
  bit          stall_on = 1'b0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model built from R1, R2, R4, R5.
  task automatic expect_for(input logic [31:0] x, input int grp, input string req);
    item_t  it;
    longint lower, v;
    bit     up;
    lower = longint'($signed(x)) >>> 11;
    up    = (m_lfsr[10:0] < x[10:0]);
    v     = lower + (up ? 1 : 0);
    if (v > 32767) begin
      it.d = 16'h7FFF; it.s = 1'b1;
    end else if (v < -32768) begin
      it.d = 16'h8000; it.s = 1'b1;
    end else begin
      it.d = v[15:0]; it.s = 1'b0;
    end
    it.grp = grp;
    it.req = req;
    sb.push_back(it);
    m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
  endtask

  task automatic send(input logic [31:0] x, input int grp, input string req);
    bit taken = 1'b0;
    while (!taken) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = x;
      #1;
      if (in_ready) begin
        expect_for(x, grp, req);
        taken = 1'b1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (sb.size() != 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Monitor: sample 2 ns after the falling edge, after inputs settle.
  logic [15:0] held_d;
  logic        held_s;
  bit          held = 1'b0;
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (held) begin
        check(out_valid && out_data == held_d && out_sat == held_s, "R7 hold", out_data, held_d);
        held = 1'b0;
      end
      if (out_valid && !out_ready) begin
        check(!in_ready, "R7 in_ready low under stall", in_ready, 0);
        held_d = out_data;
        held_s = out_sat;
        held   = 1'b1;
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected output", out_data, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(out_data == it.d, it.req, $signed(out_data), $signed(it.d));
          check(out_sat == it.s, {it.req, " sat"}, out_sat, it.s);
          if (it.grp == 1) acc1 += longint'($signed(out_data));
          if (it.grp == 2) acc2 += longint'($signed(out_data));
        end
      end
    end
  end

  // Back-pressure generator for the random phase (R7).
  always begin
    @(negedge clk);
    if (stall_on) out_ready = ($urandom_range(0, 2) != 0);
    else          out_ready = 1'b1;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R6 / R9: reset state
    check(out_valid == 1'b0, "R6 reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R7 reset in_ready", in_ready, 1);

    // R9: first draw uses seed low bits (residue chosen just above/below them)
    send({21'd5, SEED[10:0] + 11'd1}, 0, "R9 first draw up");
    send(32'h0000_0000, 0, "R3 zero");
    // R3: on-grid values pass through
    send(32'h0123_4800, 0, "R3 grid positive");
    send(32'hFEDC_B800, 0, "R3 grid negative");
    send(32'h03FF_F800, 0, "R3 grid max");
    send(32'hFC00_0000, 0, "R3 grid min");
    // R1/R2: smallest and largest residue
    send(32'h0000_0801, 0, "R2 residue one");
    send(32'h0000_0FFF, 0, "R2 residue max");
    send(32'hFFFF_F801, 0, "R1 negative floor");
    // R4: saturation
    send(32'h7FFF_FFFF, 0, "R4 sat high");
    send(32'h8000_0000, 0, "R4 sat low");
    send(32'h03FF_FFFF, 0, "R4 edge round up");
    send(32'hFBFF_FFFF, 0, "R4 edge below min");
    send(32'h0400_0000, 0, "R4 just above max");
    drain();

    // R2/R5/R7: random words under back-pressure
    stall_on = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (i % 2 == 0) r = {{6{r[26]}}, r[25:0]};
      send(r, 0, "R2 random");
    end
    drain();
    stall_on = 1'b0;

    // R8: mean tests, residue 1/2 and 1/8
    for (int i = 0; i < 3000; i++) send({21'd100, 11'd1024}, 1, "R8 half");
    for (int i = 0; i < 3000; i++) send({-21'sd7, 11'd256}, 2, "R8 eighth");
    drain();
    // mean*3000 = 100.5*3000 = 301500 ; -6.875*3000 = -20625
    check(acc1 > 301350 && acc1 < 301650, "R8 mean half", acc1, 301500);
    check(acc2 > -20775 && acc2 < -20475, "R8 mean eighth", acc2, -20625);

    check(sb.size() == 0, "R6 all results returned", sb.size(), 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule